// File: doc/BRIEF.md
# Audio Sample Receive Formatter

This block sits behind the line decoder of a two-channel digital audio receiver. Each cycle in which `sf_valid` is high it takes one decoded subframe: a 24-bit audio slot, the validity, user, channel-status and parity bits, a start-of-block marker and a channel flag (0 = left/first, 1 = right/second). It decides whether the subframe is kept, shapes the kept sample into a 32-bit word and places that word in a holding register for the consumer.

Static mode inputs select the behaviour. They choose whether subframes flagged invalid are dropped and whether block-start subframes are dropped. They set the sample width (24, 20 or 16 bits), whether parity is checked, whether the output byte order is reversed, and whether two 16-bit samples share one word. The consumer sees the holding word and a ready flag and pulses a read strobe. Sticky parity-error and overrun flags stay set until a clear pulse.

Top module: `aud_rx_formatter`

## Requirements
- R1: While `rx_en` is low, no subframe changes `hold_word`, `hold_rdy` is 0 one cycle later, and any half-built packed pair is discarded.
- R2: With `cfg_vdrop` = 1 a subframe whose validity bit is 1 is not loaded; with `cfg_vdrop` = 0 it is loaded like any other.
- R3: With `cfg_sobdrop` = 1 a subframe with `sf_sob` = 1 is not loaded; with `cfg_sobdrop` = 0 it is loaded.
- R4: `cfg_width` code 0 selects 24 bits, 1 selects 20 bits and 2 selects 16 bits (code = 6 - width/4; code 3 acts as 24). The sample is taken from the most significant bits of the slot, right-justified and sign-extended to 32 bits.
- R5: `cfg_big_end` = 0 leaves the 32-bit word as formed. `cfg_big_end` = 1 reverses its four bytes, so byte 0 goes to bits 31:24 and byte 3 goes to bits 7:0.
- R6: With `cfg_pack` = 1 and width code 2, a channel-0 sample is held as the low half (a newer one replaces it). The next channel-1 sample forms the high half and loads the word, with the byte order of R5 applied to the whole word. A channel-1 sample that finds no held half is dropped.
- R7: With `cfg_nopar` = 0, a subframe seen while enabled whose XOR over slot, validity, user, channel-status and parity bits is 1 sets `par_err`, whether or not the subframe is kept. With `cfg_nopar` = 1 parity never sets it.
- R8: A load sets `hold_rdy` on the next cycle. A `hold_rd` pulse without a load in the same cycle clears it, and a load in the same cycle as a read keeps it set.
- R9: A load while `hold_rdy` is 1 and `hold_rd` is 0 sets `ovr_flag`, and the new word replaces the old one.
- R10: `par_err` and `ovr_flag` stay set until a `flag_clr` pulse; `hold_rd` does not clear them, and a new error event in the clear cycle wins.
- R11: After reset `hold_word` is 0 and `hold_rdy`, `par_err` and `ovr_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| sf_valid | input | 1 | Subframe strobe |
| sf_slot | input | 24 | Audio slot, MSB aligned |
| sf_vbit | input | 1 | Validity bit (1 = invalid) |
| sf_ubit | input | 1 | User bit |
| sf_cbit | input | 1 | Channel-status bit |
| sf_pbit | input | 1 | Parity bit |
| sf_sob | input | 1 | Start-of-block marker |
| sf_chan | input | 1 | Channel flag, 0 first / 1 second |
| cfg_vdrop | input | 1 | Drop invalid subframes |
| cfg_big_end | input | 1 | Reverse output byte order |
| cfg_width | input | 2 | Width code 0/1/2 = 24/20/16 bits |
| cfg_nopar | input | 1 | Disable parity check |
| cfg_pack | input | 1 | Pack two 16-bit samples per word |
| cfg_sobdrop | input | 1 | Drop block-start subframes |
| hold_rd | input | 1 | Holding register read strobe |
| flag_clr | input | 1 | Clear sticky flags |
| hold_word | output | 32 | Holding register word |
| hold_rdy | output | 1 | Unread word present |
| par_err | output | 1 | Sticky parity error |
| ovr_flag | output | 1 | Sticky overrun |

## Verification
Directed subframes with negative, positive and boundary slots run through each width code and both byte orders. This separates sign extension from zero fill and the three truncation points, and it shows which byte lands where. Packed runs use left/right pairs, lone right samples and repeated left samples to show pairing order and replacement. A long random stream then mixes invalid and block-start subframes, corrupted parity, disabled cycles, reads coinciding with loads and mid-stream mode changes. A model in the bench predicts the word and every flag after each cycle, so a wrong drop decision is told apart from a wrong format or a wrong flag priority.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

   typedef enum logic [1:0] {
      WCODE_24  = 2'd0,
      WCODE_20  = 2'd1,
      WCODE_16  = 2'd2,
      WCODE_RSV = 2'd3
   } wcode_e;

   typedef struct packed {
      logic vbit;
      logic ubit;
      logic cbit;
      logic pbit;
      logic sob;
      logic chan;
   } sf_flags_t;

   // right shift that leaves the chosen number of top slot bits
   function automatic int unsigned drop_bits(input logic [1:0] code);
      case (code)
         WCODE_20: drop_bits = 4;
         WCODE_16: drop_bits = 8;
         default:  drop_bits = 0;
      endcase
   endfunction

endpackage

// File: rtl/aud_rx_filter.sv
module aud_rx_filter
   import aud_rx_pkg::*;
#(
   parameter int SLOT_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              sf_valid,
   input  logic [SLOT_W-1:0] slot,
   input  sf_flags_t         flags,
   input  logic              cfg_vdrop,
   input  logic              cfg_sobdrop,
   input  logic              cfg_nopar,
   output logic              accept,
   output logic              par_fail
);

   logic seen;
   logic drop_v;
   logic drop_s;
   logic odd_sum;

   always_comb begin
      seen    = rx_en && sf_valid;
      drop_v  = cfg_vdrop && flags.vbit;
      drop_s  = cfg_sobdrop && flags.sob;
      odd_sum = ^{slot, flags.vbit, flags.ubit, flags.cbit, flags.pbit};
      accept  = seen && !drop_v && !drop_s;
      par_fail = seen && !cfg_nopar && odd_sum;
   end

   // R7
   nopar_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_nopar |-> !par_fail);

   // R3
   sob_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_valid && cfg_sobdrop && flags.sob) |-> !accept);

   // R1
   idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> (!accept && !par_fail));

endmodule

// File: rtl/aud_rx_shaper.sv
module aud_rx_shaper
   import aud_rx_pkg::*;
#(
   parameter int SLOT_W  = 24,
   parameter int WORD_W  = 32,
   parameter bit PACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              accept,
   input  logic [SLOT_W-1:0] slot,
   input  logic              chan,
   input  logic [1:0]        cfg_width,
   input  logic              cfg_big_end,
   input  logic              cfg_pack,
   output logic              load,
   output logic [WORD_W-1:0] word
);

   localparam int HALF_W = WORD_W / 2;
   localparam int NBYTE  = WORD_W / 8;
   localparam int EXT_W  = WORD_W - SLOT_W;

   // elaboration-time parameter checks
   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("aud_rx_shaper: WORD_W must be a whole number of bytes");
   end
   if (SLOT_W < 16 || WORD_W <= SLOT_W) begin : g_bad_slot
      $error("aud_rx_shaper: need 16 <= SLOT_W < WORD_W");
   end
   if (PACK_EN && HALF_W != 16) begin : g_bad_pack
      $error("aud_rx_shaper: packing needs a 32-bit word");
   end

   logic signed [WORD_W-1:0] ext_word;
   logic        [WORD_W-1:0] pre_word;

   // width selection: keep the top bits, right-justify, sign-extend
   always_comb begin
      logic signed [WORD_W-1:0] wide;
      wide     = {{EXT_W{slot[SLOT_W-1]}}, slot};
      ext_word = wide >>> drop_bits(cfg_width);
   end

   if (PACK_EN) begin : g_pack
      logic              pend_q;
      logic [HALF_W-1:0] pdat_q;
      logic              pack16;
      logic              left_in;
      logic              right_in;

      always_comb begin
         pack16   = cfg_pack && (cfg_width == WCODE_16);
         left_in  = accept && pack16 && !chan;
         right_in = accept && pack16 && chan;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            pdat_q <= '0;
         end else if (!rx_en) begin
            pend_q <= 1'b0;
         end else if (left_in) begin
            pend_q <= 1'b1;
            pdat_q <= slot[SLOT_W-1 -: HALF_W];
         end else if (right_in) begin
            pend_q <= 1'b0;
         end
      end

      always_comb begin
         if (pack16) begin
            load     = right_in && pend_q;
            pre_word = {slot[SLOT_W-1 -: HALF_W], pdat_q};
         end else begin
            load     = accept;
            pre_word = ext_word;
         end
      end

      // R1
      pend_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rx_en |=> !pend_q);

      // R6
      lone_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (right_in && !pend_q) |-> !load);

      // R6
      left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         left_in |=> pend_q);
   end else begin : g_nopack
      always_comb begin
         load     = accept;
         pre_word = ext_word;
      end
   end

   // byte order lanes
   for (genvar b = 0; b < NBYTE; b++) begin : g_lane
      assign word[8*b +: 8] = cfg_big_end ? pre_word[8*(NBYTE-1-b) +: 8]
                                          : pre_word[8*b +: 8];
   end

   // R5
   lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_big_end |-> (word[7:0] == pre_word[WORD_W-1 -: 8]));

endmodule

// File: rtl/aud_rx_holdreg.sv
module aud_rx_holdreg #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   input  logic              par_fail,
   input  logic              hold_rd,
   input  logic              flag_clr,
   output logic [WORD_W-1:0] hold_word,
   output logic              hold_rdy,
   output logic              par_err,
   output logic              ovr_flag
);

   logic overrun_ev;

   always_comb overrun_ev = load && hold_rdy && !hold_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_word <= '0;
         hold_rdy  <= 1'b0;
         par_err   <= 1'b0;
         ovr_flag  <= 1'b0;
      end else begin
         if (load) hold_word <= word;

         if (!rx_en)       hold_rdy <= 1'b0;
         else if (load)    hold_rdy <= 1'b1;
         else if (hold_rd) hold_rdy <= 1'b0;

         if (overrun_ev)    ovr_flag <= 1'b1;
         else if (flag_clr) ovr_flag <= 1'b0;

         if (par_fail)      par_err <= 1'b1;
         else if (flag_clr) par_err <= 1'b0;
      end
   end

   // R8
   rdy_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> hold_rdy);

   // R8
   rd_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_rd && !load) |=> !hold_rdy);

   // R1
   off_not_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !hold_rdy);

   // R9
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && hold_rdy && !hold_rd) |=> ovr_flag);

   // R10
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !flag_clr) |=> ovr_flag);

   // R10
   par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err && !flag_clr) |=> par_err);

   // R7
   par_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_fail |=> par_err);

endmodule

// File: rtl/aud_rx_formatter.sv
module aud_rx_formatter
   import aud_rx_pkg::*;
#(
   parameter int SLOT_W  = 24,
   parameter int WORD_W  = 32,
   parameter bit PACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              sf_valid,
   input  logic [SLOT_W-1:0] sf_slot,
   input  logic              sf_vbit,
   input  logic              sf_ubit,
   input  logic              sf_cbit,
   input  logic              sf_pbit,
   input  logic              sf_sob,
   input  logic              sf_chan,
   input  logic              cfg_vdrop,
   input  logic              cfg_big_end,
   input  logic [1:0]        cfg_width,
   input  logic              cfg_nopar,
   input  logic              cfg_pack,
   input  logic              cfg_sobdrop,
   input  logic              hold_rd,
   input  logic              flag_clr,
   output logic [WORD_W-1:0] hold_word,
   output logic              hold_rdy,
   output logic              par_err,
   output logic              ovr_flag
);

   sf_flags_t         flags;
   logic              accept;
   logic              par_fail;
   logic              load;
   logic [WORD_W-1:0] word;

   always_comb begin
      flags.vbit = sf_vbit;
      flags.ubit = sf_ubit;
      flags.cbit = sf_cbit;
      flags.pbit = sf_pbit;
      flags.sob  = sf_sob;
      flags.chan = sf_chan;
   end

   aud_rx_filter #(.SLOT_W(SLOT_W)) u_filter (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_en       (rx_en),
      .sf_valid    (sf_valid),
      .slot        (sf_slot),
      .flags       (flags),
      .cfg_vdrop   (cfg_vdrop),
      .cfg_sobdrop (cfg_sobdrop),
      .cfg_nopar   (cfg_nopar),
      .accept      (accept),
      .par_fail    (par_fail)
   );

   aud_rx_shaper #(.SLOT_W(SLOT_W), .WORD_W(WORD_W), .PACK_EN(PACK_EN)) u_shaper (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_en       (rx_en),
      .accept      (accept),
      .slot        (sf_slot),
      .chan        (flags.chan),
      .cfg_width   (cfg_width),
      .cfg_big_end (cfg_big_end),
      .cfg_pack    (cfg_pack),
      .load        (load),
      .word        (word)
   );

   aud_rx_holdreg #(.WORD_W(WORD_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .load      (load),
      .word      (word),
      .par_fail  (par_fail),
      .hold_rd   (hold_rd),
      .flag_clr  (flag_clr),
      .hold_word (hold_word),
      .hold_rdy  (hold_rdy),
      .par_err   (par_err),
      .ovr_flag  (ovr_flag)
   );

   // R2
   vdrop_no_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && sf_valid && cfg_vdrop && sf_vbit && !hold_rdy) |=> !hold_rdy);

   // R1
   off_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> $stable(hold_word));

endmodule

// File: tb/aud_rx_formatter_test.sv
`timescale 1ns/1ps
module aud_rx_formatter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0, sf_valid = 1'b0;
   logic [23:0] sf_slot = '0;
   logic        sf_vbit = 0, sf_ubit = 0, sf_cbit = 0, sf_pbit = 0, sf_sob = 0, sf_chan = 0;
   logic        cfg_vdrop = 0, cfg_big_end = 0, cfg_nopar = 0, cfg_pack = 0, cfg_sobdrop = 0;
   logic [1:0]  cfg_width = 2'd0;
   logic        hold_rd = 0, flag_clr = 0;
   logic [31:0] hold_word;
   logic        hold_rdy, par_err, ovr_flag;

   int checks = 0;
   int errors = 0;

   // model state
   logic [31:0] m_word = '0;
   logic        m_rdy = 0, m_ovr = 0, m_par = 0, m_pend = 0;
   logic [15:0] m_pdat = '0;

   always #4 clk = ~clk;

   aud_rx_formatter uut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sf_valid(sf_valid), .sf_slot(sf_slot),
      .sf_vbit(sf_vbit), .sf_ubit(sf_ubit), .sf_cbit(sf_cbit), .sf_pbit(sf_pbit),
      .sf_sob(sf_sob), .sf_chan(sf_chan), .cfg_vdrop(cfg_vdrop), .cfg_big_end(cfg_big_end),
      .cfg_width(cfg_width), .cfg_nopar(cfg_nopar), .cfg_pack(cfg_pack),
      .cfg_sobdrop(cfg_sobdrop), .hold_rd(hold_rd), .flag_clr(flag_clr),
      .hold_word(hold_word), .hold_rdy(hold_rdy), .par_err(par_err), .ovr_flag(ovr_flag)
   );

   function automatic logic [31:0] fmt_ref(input logic [23:0] s, input logic [1:0] w);
      logic signed [31:0] t;
      int sh;
      sh = (w == 2'd1) ? 4 : (w == 2'd2) ? 8 : 0;
      t = {s, 8'h00};
      return t >>> (8 + sh);
   endfunction

   function automatic logic [31:0] order_ref(input logic [31:0] x, input logic big);
      logic [31:0] r;
      if (!big) return x;
      for (int i = 0; i < 4; i++) r[8*i +: 8] = x[8*(3-i) +: 8];
      return r;
   endfunction

   task automatic check(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, fld, act, exp);
      end
   endtask

   // one cycle: model the edge, then compare after it
   task automatic step(input string tag);
      logic acc, perr, ld, p16;
      logic [31:0] nw;
      acc  = rx_en && sf_valid && !(cfg_vdrop && sf_vbit) && !(cfg_sobdrop && sf_sob);
      perr = rx_en && sf_valid && !cfg_nopar && (^{sf_slot, sf_vbit, sf_ubit, sf_cbit, sf_pbit});
      p16  = cfg_pack && (cfg_width == 2'd2);
      ld = 0; nw = '0;
      if (acc) begin
         if (p16) begin
            if (!sf_chan) begin m_pend = 1; m_pdat = sf_slot[23:8]; end
            else if (m_pend) begin
               ld = 1; nw = order_ref({sf_slot[23:8], m_pdat}, cfg_big_end); m_pend = 0;
            end
         end else begin
            ld = 1; nw = order_ref(fmt_ref(sf_slot, cfg_width), cfg_big_end);
         end
      end
      if (!rx_en) m_pend = 0;
      if (ld && m_rdy && !hold_rd) m_ovr = 1; else if (flag_clr) m_ovr = 0;
      if (perr) m_par = 1; else if (flag_clr) m_par = 0;
      if (!rx_en) m_rdy = 0; else if (ld) m_rdy = 1; else if (hold_rd) m_rdy = 0;
      if (ld) m_word = nw;
      @(posedge clk); #2;
      check(tag, "word", hold_word, m_word);
      check(tag, "rdy", {31'd0, hold_rdy}, {31'd0, m_rdy});
      check(tag, "ovr", {31'd0, ovr_flag}, {31'd0, m_ovr});
      check(tag, "par", {31'd0, par_err}, {31'd0, m_par});
      sf_valid = 0; hold_rd = 0; flag_clr = 0;
   endtask

   task automatic send(input logic [23:0] s, input logic ch, input logic vb, input logic sob, input logic badpar);
      sf_valid = 1; sf_slot = s; sf_chan = ch; sf_vbit = vb; sf_sob = sob;
      sf_ubit = 0; sf_cbit = 0;
      sf_pbit = (^{s, vb, 1'b0, 1'b0}) ^ badpar;
   endtask

   initial begin
      #1_600_000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #20;
      // R11 reset state
      check("R11 reset", "word", hold_word, 32'h0);
      check("R11 reset", "flags", {29'd0, hold_rdy, par_err, ovr_flag}, 32'h0);
      @(posedge clk); #2; rst_n = 1; rx_en = 1;

      // R4 width codes, little order
      send(24'h800001, 0, 0, 0, 0); step("R4 w24 neg");
      check("R4 w24 value", "word", hold_word, 32'hFF800001);
      hold_rd = 1; step("R8 read");
      cfg_width = 2'd1; send(24'h812345, 0, 0, 0, 0); hold_rd = 0; step("R4 w20");
      check("R4 w20 value", "word", hold_word, 32'hFFF81234);
      hold_rd = 1; step("R8 read2");
      cfg_width = 2'd2; send(24'h7FFF12, 0, 0, 0, 0); step("R4 w16 pos");
      check("R4 w16 value", "word", hold_word, 32'h00007FFF);
      hold_rd = 1; step("R8 read3");
      // R5 big endian
      cfg_width = 2'd0; cfg_big_end = 1; send(24'h123456, 0, 0, 0, 0); step("R5 swap");
      check("R5 swap value", "word", hold_word, 32'h56341200);
      hold_rd = 1; cfg_big_end = 0; step("R8 read4");
      // R2 validity drop and pass
      cfg_vdrop = 1; send(24'h111111, 0, 1, 0, 0); step("R2 drop");
      check("R2 drop", "rdy", {31'd0, hold_rdy}, 32'd0);
      cfg_vdrop = 0; send(24'h222222, 0, 1, 0, 0); step("R2 keep");
      hold_rd = 1; step("R8 read5");
      // R3 block start drop and pass
      cfg_sobdrop = 1; send(24'h333333, 0, 0, 1, 0); step("R3 drop");
      check("R3 drop", "word", hold_word, 32'h00222222);
      cfg_sobdrop = 0; send(24'h333333, 0, 0, 1, 0); step("R3 keep");
      // R9 overrun, R8 read with load keeps ready
      send(24'h444444, 0, 0, 0, 0); step("R9 overrun");
      check("R9 overrun", "ovr", {31'd0, ovr_flag}, 32'd1);
      send(24'h555555, 0, 0, 0, 0); hold_rd = 1; step("R8 read+load");
      // R10 clear
      hold_rd = 1; step("R10 read keeps ovr");
      flag_clr = 1; step("R10 clear");
      // R7 parity
      send(24'h010203, 0, 0, 0, 1); step("R7 bad parity");
      check("R7 flag", "par", {31'd0, par_err}, 32'd1);
      flag_clr = 1; cfg_nopar = 1; send(24'h010203, 0, 0, 0, 1); step("R7 disabled");
      cfg_nopar = 0; hold_rd = 1; step("R8 read6");
      // R6 packing
      cfg_width = 2'd2; cfg_pack = 1;
      send(24'hAAAA00, 1, 0, 0, 0); step("R6 lone right");
      send(24'h111100, 0, 0, 0, 0); step("R6 left");
      send(24'h123400, 0, 0, 0, 0); step("R6 left replace");
      send(24'hBEEF00, 1, 0, 0, 0); step("R6 right");
      check("R6 pair", "word", hold_word, 32'hBEEF1234);
      hold_rd = 1; step("R8 read7");
      // R1 disabled
      send(24'h999900, 0, 0, 0, 0); step("R6 left2");
      rx_en = 0; send(24'h777777, 1, 0, 0, 0); step("R1 off");
      rx_en = 1; send(24'h888800, 1, 0, 0, 0); step("R1 pair flushed");
      check("R1 flushed", "rdy", {31'd0, hold_rdy}, 32'd0);
      cfg_pack = 0; cfg_width = 2'd0;

      // random mix
      for (int i = 0; i < 6000; i++) begin
         if (i % 97 == 0) begin
            cfg_vdrop = $urandom_range(0, 1); cfg_sobdrop = $urandom_range(0, 1);
            cfg_big_end = $urandom_range(0, 1); cfg_width = 2'($urandom_range(0, 3));
            cfg_nopar = $urandom_range(0, 1); cfg_pack = $urandom_range(0, 1);
         end
         rx_en = ($urandom_range(0, 19) != 0);
         if ($urandom_range(0, 9) < 6)
            send(24'($urandom), 1'($urandom), ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
         hold_rd  = ($urandom_range(0, 9) < 4);
         flag_clr = ($urandom_range(0, 19) == 0);
         step("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_A0D1));
   end

endmodule